// File: doc/BRIEF.md
# Four-Phase I2C Bit Timing Generator

This block times each bit on an I2C bus for the byte sequencer that sits above it. The sequencer hands over one bit command at a time: a data bit, a start condition or a stop condition. The generator then steps the SCL and SDA line levels through four phases, P0 to P3. It raises one-cycle strobes at the moments when SDA may change, when SCL rises, when SDA is sampled, when SCL falls and when the bit ends. SDA is captured into `rx_bit` at the sampling moment.

Time is measured in prescaler ticks. A divider register sets how many system clocks make one tick. A phase register holds four separate tick counts, one for each phase. Because the four counts are independent, setup, high, sample-hold and low times can be uneven. For example, P0 can be stretched to cover a slowly rising bus. Common settings with a 24 MHz system clock are divider 1 with counts 5/5/5/11, divider 1 with 15/12/12/21, and divider 10 with 9/6/5/4.

The controller state machine has five states: IDLE, P0, P1, P2 and P3. It moves from IDLE to P0 when a command is accepted. From each phase it moves to the next when that phase's tick count runs out, and from P3 it returns to IDLE. Dropping `enable` sends the machine to IDLE from any state and releases both lines. The divider and phase registers keep their values.

Top module: `i2cbt_top`

## Requirements
- R1: After reset, `scl_o` and `sda_o` are 1, all strobes are 0, `rx_bit` is 0, and `cmd_ready` equals `enable`.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle `cmd_ready` stays 0 until the bit completes.
- R3: Phase k lasts eff(Pk)*eff(D) cycles, where eff(x) is x, or 1 when x is 0. The phases run back to back in the order P0, P1, P2, P3. `cmd_ready` returns to 1 in the cycle after the last P3 cycle.
- R4: For a data bit (`cmd_kind` 0), SDA equals `cmd_bit` in all four phases. SCL is 0 in P0 and P3 and 1 in P1 and P2. Kind 3 behaves as a data bit.
- R5: For a start (`cmd_kind` 1), {SCL,SDA} is 01, 11, 10, 00 in P0..P3, so SDA falls while SCL is high.
- R6: For a stop (`cmd_kind` 2), {SCL,SDA} is 00, 10, 11, 11 in P0..P3, so SDA rises while SCL is high.
- R7: `chg_stb` marks the first P0 cycle, `rise_stb` the first P1 cycle, `smp_stb` the last P2 cycle, `fall_stb` the first P3 cycle, and `done_stb` the last P3 cycle. Each strobe lasts one cycle.
- R8: `rx_bit` takes the value of `sda_i` from the `smp_stb` cycle on the following edge, and holds at all other times.
- R9: While IDLE after a bit, the lines hold the levels of that bit's P3.
- R10: A write to the divider or phase register made during a bit does not change that bit's timing. It applies from the next accepted command.
- R11: A divider or phase count of 0 acts as 1.
- R12: When `enable` is 0, on the next edge the machine returns to IDLE with both lines at 1. Strobes stay 0 and `cmd_ready` is 0. The divider and phase registers keep their contents.
- R13: Register writes (`cfg_sel` 0: divider in `cfg_wdata[7:0]`; `cfg_sel` 1: P0 in bits 7:0, P1 in 15:8, P2 in 23:16, P3 in 31:24) take effect on the clock edge and are accepted whether or not `enable` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enabled; 0 resets the timing machine |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects divider, 1 selects phase counts |
| cfg_wdata | input | 32 | Register write data |
| cmd_valid | input | 1 | Bit command offered |
| cmd_kind | input | 2 | 0 data, 1 start, 2 stop, 3 data |
| cmd_bit | input | 1 | SDA level for a data bit |
| cmd_ready | output | 1 | Command can be taken |
| sda_i | input | 1 | Sensed SDA level |
| scl_o | output | 1 | SCL level (1 = released) |
| sda_o | output | 1 | SDA level (1 = released) |
| chg_stb | output | 1 | SDA may change (start of P0) |
| rise_stb | output | 1 | SCL rises (start of P1) |
| smp_stb | output | 1 | SDA sampled (end of P2) |
| fall_stb | output | 1 | SCL falls (start of P3) |
| done_stb | output | 1 | Bit ends (end of P3) |
| rx_bit | output | 1 | Last sampled SDA |

## Verification
The assertions assume that `cmd_kind` and `cmd_bit` are stable only in the cycle of acceptance, since they are latched there. They also assume that `sda_i` may change at any time, because only its value in the sampling cycle matters. The stimulus offers commands only when `cmd_ready` is 1 and keeps divider and phase values small, so every bit completes within a few hundred cycles. Only the directed disable case drops `enable` mid-bit, and it does so before the sampling point.

// File: rtl/i2cbt_pkg.sv
package i2cbt_pkg;

    localparam int unsigned NUM_PHASES = 4;
    localparam int unsigned PH_IDX_W   = $clog2(NUM_PHASES);

    typedef enum logic [1:0] {
        K_DATA  = 2'd0,
        K_START = 2'd1,
        K_STOP  = 2'd2,
        K_ALT   = 2'd3
    } bit_kind_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_P0   = 3'd1,
        S_P1   = 3'd2,
        S_P2   = 3'd3,
        S_P3   = 3'd4
    } phase_st_t;

endpackage

// File: rtl/i2cbt_cfg_regs.sv
module i2cbt_cfg_regs #(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned PH_W  = 8,
    parameter int unsigned NPH   = 4,
    localparam int unsigned CFG_W = NPH * PH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [CFG_W-1:0] wdata,
    output logic [DIV_W-1:0] div_q,
    output logic [CFG_W-1:0] ph_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_W'(1);
        end else if (we && !sel) begin
            div_q <= wdata[DIV_W-1:0];
        end
    end

    for (genvar g = 0; g < NPH; g++) begin : g_phase_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ph_q[g*PH_W +: PH_W] <= PH_W'(1);
            end else if (we && sel) begin
                ph_q[g*PH_W +: PH_W] <= wdata[g*PH_W +: PH_W];
            end
        end
    end

endmodule

// File: rtl/i2cbt_presc.sv
module i2cbt_presc #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - 1'b1;
    assign tick = run && (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2cbt_fsm.sv
module i2cbt_fsm
    import i2cbt_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned PH_W  = 8,
    localparam int unsigned CFG_W = NUM_PHASES * PH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_bit,
    input  logic             sda_i,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [CFG_W-1:0] ph_cfg,
    input  logic             tick,
    output logic [DIV_W-1:0] sh_div,
    output logic             presc_clear,
    output logic             presc_run,
    output logic             cmd_ready,
    output logic             scl_o,
    output logic             sda_o,
    output logic             chg_stb,
    output logic             rise_stb,
    output logic             smp_stb,
    output logic             fall_stb,
    output logic             done_stb,
    output logic             rx_bit
);

    phase_st_t           state_q, state_d;
    bit_kind_t           kind_q;
    logic                bit_q;
    logic [CFG_W-1:0]    sh_ph;
    logic [PH_W-1:0]     tc_q;
    logic                first_q;
    logic                idle_scl_q, idle_sda_q;
    logic                rx_q;
    logic [PH_IDX_W-1:0] idx;
    logic [PH_W-1:0]     len_raw, len_m1;
    logic                busy, accept, phase_end;

    // {scl, sda} for a given command kind and phase index
    function automatic logic [1:0] line_lv(bit_kind_t k, logic b, logic [PH_IDX_W-1:0] p);
        logic [1:0] v;
        unique case (k)
            K_START: begin
                case (p)
                    2'd0:    v = 2'b01;
                    2'd1:    v = 2'b11;
                    2'd2:    v = 2'b10;
                    default: v = 2'b00;
                endcase
            end
            K_STOP: begin
                case (p)
                    2'd0:    v = 2'b00;
                    2'd1:    v = 2'b10;
                    default: v = 2'b11;
                endcase
            end
            default: v = {(p == 2'd1) || (p == 2'd2), b};
        endcase
        return v;
    endfunction

    assign busy      = (state_q != S_IDLE);
    assign cmd_ready = enable && !busy;
    assign accept    = cmd_valid && cmd_ready;

    always_comb begin
        unique case (state_q)
            S_P1:    idx = 2'd1;
            S_P2:    idx = 2'd2;
            S_P3:    idx = 2'd3;
            default: idx = 2'd0;
        endcase
    end

    assign len_raw   = sh_ph[idx*PH_W +: PH_W];
    assign len_m1    = (len_raw == '0) ? '0 : len_raw - 1'b1;
    assign phase_end = busy && tick && (tc_q >= len_m1);

    assign presc_clear = accept || !enable;
    assign presc_run   = busy;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept)    state_d = S_P0;
            S_P0:    if (phase_end) state_d = S_P1;
            S_P1:    if (phase_end) state_d = S_P2;
            S_P2:    if (phase_end) state_d = S_P3;
            S_P3:    if (phase_end) state_d = S_IDLE;
            default:                state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else if (!enable) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // phase counter, shadow configuration, idle levels, sampled bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tc_q       <= '0;
            first_q    <= 1'b0;
            kind_q     <= K_DATA;
            bit_q      <= 1'b1;
            sh_div     <= '0;
            sh_ph      <= '0;
            idle_scl_q <= 1'b1;
            idle_sda_q <= 1'b1;
            rx_q       <= 1'b0;
        end else if (!enable) begin
            tc_q       <= '0;
            first_q    <= 1'b0;
            idle_scl_q <= 1'b1;
            idle_sda_q <= 1'b1;
        end else begin
            if (accept) begin
                tc_q    <= '0;
                first_q <= 1'b1;
                kind_q  <= bit_kind_t'(cmd_kind);
                bit_q   <= cmd_bit;
                sh_div  <= div_cfg;
                sh_ph   <= ph_cfg;
            end else if (busy) begin
                first_q <= phase_end && (state_q != S_P3);
                if (tick) begin
                    tc_q <= phase_end ? '0 : tc_q + 1'b1;
                end
            end
            if (smp_stb) begin
                rx_q <= sda_i;
            end
            if (done_stb) begin
                idle_scl_q <= scl_o;
                idle_sda_q <= sda_o;
            end
        end
    end

    // outputs
    always_comb begin
        logic [1:0] lv;
        lv       = line_lv(kind_q, bit_q, idx);
        scl_o    = idle_scl_q;
        sda_o    = idle_sda_q;
        chg_stb  = 1'b0;
        rise_stb = 1'b0;
        smp_stb  = 1'b0;
        fall_stb = 1'b0;
        done_stb = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_P0: begin
                {scl_o, sda_o} = lv;
                chg_stb        = first_q;
            end
            S_P1: begin
                {scl_o, sda_o} = lv;
                rise_stb       = first_q;
            end
            S_P2: begin
                {scl_o, sda_o} = lv;
                smp_stb        = phase_end;
            end
            S_P3: begin
                {scl_o, sda_o} = lv;
                fall_stb       = first_q;
                done_stb       = phase_end;
            end
            default: ;
        endcase
    end

    assign rx_bit = rx_q;

endmodule

// File: rtl/i2cbt_top.sv
module i2cbt_top
    import i2cbt_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned PH_W  = 8,
    localparam int unsigned CFG_W = NUM_PHASES * PH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_bit,
    output logic             cmd_ready,
    input  logic             sda_i,
    output logic             scl_o,
    output logic             sda_o,
    output logic             chg_stb,
    output logic             rise_stb,
    output logic             smp_stb,
    output logic             fall_stb,
    output logic             done_stb,
    output logic             rx_bit
);

    logic [DIV_W-1:0] div_q, sh_div;
    logic [CFG_W-1:0] ph_q;
    logic             tick, presc_clear, presc_run;

    i2cbt_cfg_regs #(.DIV_W(DIV_W), .PH_W(PH_W), .NPH(NUM_PHASES)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .div_q (div_q),
        .ph_q  (ph_q)
    );

    i2cbt_presc #(.DIV_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (presc_clear),
        .run   (presc_run),
        .div   (sh_div),
        .tick  (tick)
    );

    i2cbt_fsm #(.DIV_W(DIV_W), .PH_W(PH_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cmd_valid   (cmd_valid),
        .cmd_kind    (cmd_kind),
        .cmd_bit     (cmd_bit),
        .sda_i       (sda_i),
        .div_cfg     (div_q),
        .ph_cfg      (ph_q),
        .tick        (tick),
        .sh_div      (sh_div),
        .presc_clear (presc_clear),
        .presc_run   (presc_run),
        .cmd_ready   (cmd_ready),
        .scl_o       (scl_o),
        .sda_o       (sda_o),
        .chg_stb     (chg_stb),
        .rise_stb    (rise_stb),
        .smp_stb     (smp_stb),
        .fall_stb    (fall_stb),
        .done_stb    (done_stb),
        .rx_bit      (rx_bit)
    );

endmodule

// File: rtl/i2cbt_chk.sv
module i2cbt_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic sda_i,
    input logic scl_o,
    input logic sda_o,
    input logic chg_stb,
    input logic rise_stb,
    input logic smp_stb,
    input logic fall_stb,
    input logic done_stb,
    input logic rx_bit
);

    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chg_stb, rise_stb, smp_stb, fall_stb}));

    a_r4_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        chg_stb |-> !scl_o);

    a_r4_rise_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> scl_o);

    a_r8_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> (rx_bit == $past(sda_i)));

    a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_stb |=> $stable(rx_bit));

    a_r12_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && sda_o && !chg_stb && !rise_stb && !smp_stb && !fall_stb && !done_stb));

    a_r3_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |=> (cmd_ready || !enable));

endmodule

bind i2cbt_top i2cbt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .sda_i     (sda_i),
    .scl_o     (scl_o),
    .sda_o     (sda_o),
    .chg_stb   (chg_stb),
    .rise_stb  (rise_stb),
    .smp_stb   (smp_stb),
    .fall_stb  (fall_stb),
    .done_stb  (done_stb),
    .rx_bit    (rx_bit)
);

// File: tb/tb_i2cbt_top.sv
`timescale 1ns/1ps
module tb_i2cbt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic        cmd_bit = 1'b0;
    logic        cmd_ready;
    logic        sda_i = 1'b1;
    logic        scl_o, sda_o, chg_stb, rise_stb, smp_stb, fall_stb, done_stb, rx_bit;

    always #4 clk = ~clk;

    i2cbt_top dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bit(cmd_bit),
        .cmd_ready(cmd_ready), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
        .chg_stb(chg_stb), .rise_stb(rise_stb), .smp_stb(smp_stb),
        .fall_stb(fall_stb), .done_stb(done_stb), .rx_bit(rx_bit)
    );

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    int   cur_div = 1;
    int   cur_ph[4] = '{1, 1, 1, 1};
    logic exp_rx = 1'b0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int eff(int x);
        return (x == 0) ? 1 : x;
    endfunction

    // expected {scl, sda}
    function automatic logic [1:0] exp_lv(int kind, logic b, int ph);
        if (kind == 1) begin
            case (ph) 0: return 2'b01; 1: return 2'b11; 2: return 2'b10; default: return 2'b00; endcase
        end else if (kind == 2) begin
            case (ph) 0: return 2'b00; 1: return 2'b10; default: return 2'b11; endcase
        end
        return {(ph == 1) || (ph == 2), b};
    endfunction

    function automatic string lv_req(int kind);
        return (kind == 1) ? "R5 start levels" : (kind == 2) ? "R6 stop levels" : "R4 data levels";
    endfunction

    task automatic cfg_write(logic sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!sel) cur_div = int'(data[7:0]);
        else for (int k = 0; k < 4; k++) cur_ph[k] = int'(data[k*8 +: 8]);
    endtask

    function automatic logic [31:0] pack_ph(int a, int b, int c, int d);
        return {d[7:0], c[7:0], b[7:0], a[7:0]};
    endfunction

    // called right after a negedge; ends right after a negedge
    task automatic run_bit(int kind, logic b, logic sv, bit midwrite, int new_div);
        int ediv, total, acc, ph, off, len;
        int lens[4];
        logic prev_rx;
        logic [1:0] p3lv;
        ediv = eff(cur_div);
        total = 0;
        for (int k = 0; k < 4; k++) begin
            lens[k] = eff(cur_ph[k]) * ediv;
            total += lens[k];
        end
        prev_rx = exp_rx;
        check("R2 ready before accept", {31'd0, cmd_ready}, 32'd1);
        cmd_valid = 1'b1; cmd_kind = kind[1:0]; cmd_bit = b; sda_i = sv;
        for (int n = 0; n < total; n++) begin
            @(negedge clk);
            if (n == 0) begin
                cmd_valid = 1'b0;
                cmd_bit = ~b;
                sda_i = ~sv;
                if (midwrite) begin
                    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = new_div;
                end
            end
            if (n == 1) cfg_we = 1'b0;
            acc = 0; ph = 0;
            while (n >= acc + lens[ph]) begin acc += lens[ph]; ph++; end
            off = n - acc; len = lens[ph];
            if (ph == 2 && off == len - 1) sda_i = sv;
            check(lv_req(kind), {30'd0, scl_o, sda_o}, {30'd0, exp_lv(kind, b, ph)});
            check("R7 strobes/R3 phase length",
                  {27'd0, chg_stb, rise_stb, smp_stb, fall_stb, done_stb},
                  {27'd0, (ph == 0 && off == 0), (ph == 1 && off == 0),
                   (ph == 2 && off == len - 1), (ph == 3 && off == 0),
                   (ph == 3 && off == len - 1)});
            check("R2 ready low while busy", {31'd0, cmd_ready}, 32'd0);
            check("R8 rx held before sample", {31'd0, rx_bit},
                  {31'd0, (ph == 3) ? sv : prev_rx});
        end
        if (midwrite) cur_div = new_div;
        @(negedge clk);
        exp_rx = sv;
        p3lv = exp_lv(kind, b, 3);
        check("R3 ready after bit", {31'd0, cmd_ready}, 32'd1);
        check("R9 idle holds P3 levels", {30'd0, scl_o, sda_o}, {30'd0, p3lv});
        check("R8 rx after sample", {31'd0, rx_bit}, {31'd0, sv});
        @(negedge clk);
        check("R9 idle still holds", {30'd0, scl_o, sda_o}, {30'd0, p3lv});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset lines", {30'd0, scl_o, sda_o}, 32'd3);
        check("R1 reset strobes", {27'd0, chg_stb, rise_stb, smp_stb, fall_stb, done_stb}, 32'd0);
        check("R1 reset rx", {31'd0, rx_bit}, 32'd0);
        check("R1 reset ready", {31'd0, cmd_ready}, 32'd1);

        // R11: defaults are 1; zero values clamp to 1
        cfg_write(1'b0, 32'd0);
        cfg_write(1'b1, 32'd0);
        @(negedge clk);
        run_bit(1, 1'b1, 1'b1, 1'b0, 0);   // R11 start with zeros
        run_bit(0, 1'b0, 1'b0, 1'b0, 0);   // R11 data
        run_bit(2, 1'b0, 1'b1, 1'b0, 0);   // R11 stop

        // directed fast setting
        cfg_write(1'b0, 32'd1);
        cfg_write(1'b1, pack_ph(5, 5, 5, 11));
        @(negedge clk);
        run_bit(1, 1'b1, 1'b0, 1'b0, 0);
        run_bit(0, 1'b1, 1'b1, 1'b0, 0);
        run_bit(3, 1'b0, 1'b0, 1'b0, 0);   // R4 kind 3 as data

        // R10 mid-bit divider write: this bit keeps divider 1, next uses 3
        run_bit(0, 1'b1, 1'b0, 1'b1, 3);
        run_bit(0, 1'b0, 1'b1, 1'b0, 0);

        // slow setting
        cfg_write(1'b0, 32'd10);
        cfg_write(1'b1, pack_ph(9, 6, 5, 4));
        @(negedge clk);
        run_bit(0, 1'b1, 1'b1, 1'b0, 0);
        run_bit(2, 1'b0, 1'b0, 1'b0, 0);

        // R12/R13 disable mid-bit, registers retained, writes accepted while disabled
        cfg_write(1'b0, 32'd1);
        cfg_write(1'b1, pack_ph(5, 5, 5, 5));
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'd0; cmd_bit = 1'b0;
        @(negedge clk); cmd_valid = 1'b0;
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R12 disable releases lines", {30'd0, scl_o, sda_o}, 32'd3);
        check("R12 disable strobes", {27'd0, chg_stb, rise_stb, smp_stb, fall_stb, done_stb}, 32'd0);
        check("R12 ready low", {31'd0, cmd_ready}, 32'd0);
        check("R12 rx kept", {31'd0, rx_bit}, {31'd0, exp_rx});
        cfg_write(1'b1, pack_ph(2, 3, 1, 2));   // R13 write while disabled
        check("R12 still released", {30'd0, scl_o, sda_o}, 32'd3);
        enable = 1'b1;
        @(negedge clk);
        check("R12 ready after enable", {31'd0, cmd_ready}, 32'd1);
        run_bit(1, 1'b0, 1'b1, 1'b0, 0);        // R13 new phases, R12 divider kept

        // random mix
        for (int i = 0; i < 60; i++) begin
            if ($urandom_range(0, 4) == 0) begin
                cfg_write(1'b0, $urandom_range(0, 3));
                cfg_write(1'b1, pack_ph($urandom_range(0, 9), $urandom_range(0, 9),
                                        $urandom_range(0, 9), $urandom_range(0, 9)));
                @(negedge clk);
            end
            run_bit($urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    ($urandom_range(0, 5) == 0), $urandom_range(1, 3));
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule